// File: doc/BRIEF.md
# Per-Line DMA Transaction Tracker

The block stands between a source of DMA load and store requests and a memory-side network that answers them. Each request names a cache line. When that line is idle and a table slot is free, the request passes straight through to the downstream request channel in the same cycle, and a slot records the line and whether the access is a load or a store. The memory side later returns either a data word for a load or an acknowledge for a store. The tracker finds the slot by line address, reports the completion upstream with the line address one cycle later, and frees the slot.

Many lines can be in flight at once, up to the table depth. Only a request whose line is already in flight is held back. It waits at the request port with ready low, and it is taken in the first cycle after that line's completion has been recorded. The same back-pressure applies when every slot is occupied. A response that matches no slot, carries an unknown kind, or carries the wrong kind for its slot raises a one-cycle error pulse and changes nothing.

Top module: `dma_line_tracker`

## Requirements
- R1: After reset no line is in flight: `cmp_valid` and `rsp_err` are 0, and the first request to any line is offered downstream.
- R2: A request to an idle line with a free slot drives `dn_valid`=1 in the same cycle with `dn_line`=`req_line`. `req_ready` equals `dn_ready`, and the slot is taken only when both are 1.
- R3: `dn_write` equals `req_write` (1 = store, 0 = load), and `dn_wdata` equals `req_wdata`.
- R4: A request to a line already in flight sees `dn_valid`=0 and `req_ready`=0. It is accepted at the earliest in the cycle after the clock edge that records that line's completing response.
- R5: When all DEPTH slots are occupied, a request to any line sees `dn_valid`=0 and `req_ready`=0.
- R6: A response with `rsp_kind`=2'b01 (data) to a line in flight as a load sets, on the next cycle, `cmp_valid`=1, `cmp_write`=0, `cmp_line`=`rsp_line` and `cmp_data`=`rsp_data`, and frees the line.
- R7: A response with `rsp_kind`=2'b10 (acknowledge) to a line in flight as a store sets, on the next cycle, `cmp_valid`=1, `cmp_write`=1, `cmp_line`=`rsp_line` and `cmp_data`=0, and frees the line.
- R8: Any other response (kind 2'b00 or 2'b11, a line not in flight, or a kind that does not suit the slot) gives `rsp_err`=1 and `cmp_valid`=0 on the next cycle, and leaves the table unchanged.
- R9: `rsp_ready` is always 1. Responses may arrive in any order among the lines in flight, and each one completes its own line.
- R10: Up to DEPTH distinct lines can be in flight at once, and no line is ever held by two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Upstream request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_line | input | LINE_W | Line address of the request |
| req_wdata | input | DATA_W | Store data |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream channel can take a request |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_line | output | LINE_W | Downstream line address |
| dn_wdata | output | DATA_W | Downstream write data |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response taken (always 1) |
| rsp_kind | input | 2 | 2'b01 data, 2'b10 acknowledge, others invalid |
| rsp_line | input | LINE_W | Line address of the response |
| rsp_data | input | DATA_W | Read data |
| cmp_valid | output | 1 | Completion pulse to the request source |
| cmp_write | output | 1 | 1 = store acknowledged, 0 = load data |
| cmp_line | output | LINE_W | Line address of the completion |
| cmp_data | output | DATA_W | Load data, 0 for stores |
| rsp_err | output | 1 | Discarded-response pulse |

## Verification
The hardest case to reach from the ports is a request that hits a busy line in the same cycle as that line's completing response, because the bench must observe the stall and then the acceptance one cycle later. Line addresses are drawn from a pool of six, so collisions are frequent. Most responses are aimed at a line the bench model knows to be in flight, and request and response are driven independently each cycle, so this overlap occurs many times during the random phase. A directed sequence also fills the table, tries a fifth line, and completes two lines out of order.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_LOAD  = 2'd1,
    LS_STORE = 2'd2
  } line_state_e;

  localparam logic [1:0] RSP_DATA = 2'b01;
  localparam logic [1:0] RSP_ACK  = 2'b10;

  // State a freshly allocated slot takes for a given access direction.
  function automatic line_state_e start_state(input logic is_write);
    return is_write ? LS_STORE : LS_LOAD;
  endfunction

  // A response completes a slot only when its kind suits the slot's state.
  function automatic logic rsp_fits(input logic [1:0] kind, input line_state_e st);
    return ((kind == RSP_DATA) && (st == LS_LOAD)) ||
           ((kind == RSP_ACK)  && (st == LS_STORE));
  endfunction
endpackage

// File: rtl/dlt_entry.sv
module dlt_entry
  import dlt_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              alloc_write,
  input  logic              release_i,
  output line_state_e       state_o,
  output logic [LINE_W-1:0] line_o
);
  line_state_e       state_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      line_q  <= '0;
    end else if (alloc) begin
      state_q <= start_state(alloc_write);
      line_q  <= alloc_line;
    end else if (release_i) begin
      state_q <= LS_IDLE;
    end
  end

  assign state_o = state_q;
  assign line_o  = line_q;

  // R2
  alloc_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (state_q == LS_IDLE));
  // R6
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> (state_q != LS_IDLE));
  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (state_q == LS_IDLE));
endmodule

// File: rtl/dlt_match.sv
module dlt_match #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 16
) (
  input  logic [DEPTH-1:0][LINE_W-1:0] lines,
  input  logic [DEPTH-1:0]             busy,
  input  logic [LINE_W-1:0]            key,
  output logic [DEPTH-1:0]             hits
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hits[i] = busy[i] && (lines[i] == key);
  end
endmodule

// File: rtl/dlt_pick.sv
module dlt_pick #(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0] free_vec,
  output logic [DEPTH-1:0] gnt,
  output logic             any
);
  always_comb begin
    gnt = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_vec[i]) gnt = DEPTH'(1) << i;
    end
  end
  assign any = |free_vec;
endmodule

// File: rtl/dma_line_tracker.sv
module dma_line_tracker
  import dlt_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [LINE_W-1:0] dn_line,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              cmp_valid,
  output logic              cmp_write,
  output logic [LINE_W-1:0] cmp_line,
  output logic [DATA_W-1:0] cmp_data,
  output logic              rsp_err
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  line_state_e                 ent_state [DEPTH];
  logic [DEPTH-1:0][LINE_W-1:0] ent_line;
  logic [DEPTH-1:0]            busy_vec;
  logic [DEPTH-1:0]            alloc_vec;
  logic [DEPTH-1:0]            release_vec;
  logic [DEPTH-1:0]            req_hitv;
  logic [DEPTH-1:0]            rsp_hitv;
  logic [DEPTH-1:0]            free_gnt;
  logic                        free_any;
  logic                        req_hit;
  logic                        req_fire;
  logic                        rsp_hit;
  logic                        rsp_ok;
  logic [IDX_W-1:0]            rsp_idx;
  logic                        dup_any;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    dlt_entry #(.LINE_W(LINE_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_vec[i]),
      .alloc_line (req_line),
      .alloc_write(req_write),
      .release_i  (release_vec[i]),
      .state_o    (ent_state[i]),
      .line_o     (ent_line[i])
    );
    assign busy_vec[i]    = (ent_state[i] != LS_IDLE);
    assign alloc_vec[i]   = req_fire && free_gnt[i];
    assign release_vec[i] = rsp_ok && rsp_hitv[i];
  end

  dlt_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_req_match (
    .lines(ent_line), .busy(busy_vec), .key(req_line), .hits(req_hitv)
  );
  dlt_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_rsp_match (
    .lines(ent_line), .busy(busy_vec), .key(rsp_line), .hits(rsp_hitv)
  );
  dlt_pick #(.DEPTH(DEPTH)) u_pick (
    .free_vec(~busy_vec), .gnt(free_gnt), .any(free_any)
  );

  // Request path: a pass-through gated by the table lookup.
  assign req_hit   = |req_hitv;
  assign dn_valid  = req_valid && !req_hit && free_any;
  assign req_ready = dn_valid && dn_ready;
  assign req_fire  = req_valid && req_ready;
  assign dn_write  = req_write;
  assign dn_line   = req_line;
  assign dn_wdata  = req_wdata;

  // Response path: locate the slot and qualify the kind against its state.
  always_comb begin
    rsp_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rsp_hitv[i]) rsp_idx = IDX_W'(i);
    end
  end
  assign rsp_hit   = |rsp_hitv;
  assign rsp_ok    = rsp_valid && rsp_hit && rsp_fits(rsp_kind, ent_state[rsp_idx]);
  assign rsp_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      cmp_write <= 1'b0;
      cmp_line  <= '0;
      cmp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      cmp_valid <= rsp_ok;
      cmp_write <= rsp_ok && (rsp_kind == RSP_ACK);
      cmp_line  <= rsp_ok ? rsp_line : '0;
      cmp_data  <= (rsp_ok && (rsp_kind == RSP_DATA)) ? rsp_data : '0;
      rsp_err   <= rsp_valid && !rsp_ok;
    end
  end

  // Cross-slot uniqueness, used only by the checks below.
  always_comb begin
    dup_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if (busy_vec[i] && busy_vec[j] && (ent_line[i] == ent_line[j])) dup_any = 1'b1;
      end
    end
  end

  // R10
  unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_any);
  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busy_vec) == DEPTH) |-> !req_ready);
  // R6
  cmp_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |=> (cmp_valid && (cmp_line == $past(rsp_line))));
  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !cmp_valid);
  // R9
  one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_vec));
endmodule

// File: tb/tb_dma_line_tracker.sv
module tb_dma_line_tracker;
  localparam int DEPTH = 4;
  localparam int LW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, dn_ready = 0, rsp_valid = 0;
  logic [LW-1:0] req_line = '0, rsp_line = '0;
  logic [DW-1:0] req_wdata = '0, rsp_data = '0;
  logic [1:0] rsp_kind = '0;
  logic req_ready, dn_valid, dn_write, rsp_ready, cmp_valid, cmp_write, rsp_err;
  logic [LW-1:0] dn_line, cmp_line;
  logic [DW-1:0] dn_wdata, cmp_data;

  always #4 clk = ~clk;

  dma_line_tracker #(.DEPTH(DEPTH), .LINE_W(LW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_wdata(req_wdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_line(dn_line), .dn_wdata(dn_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_line(rsp_line), .rsp_data(rsp_data),
    .cmp_valid(cmp_valid), .cmp_write(cmp_write), .cmp_line(cmp_line),
    .cmp_data(cmp_data), .rsp_err(rsp_err)
  );

  int n_tests = 0;
  int n_fail = 0;
  int m_st [16];   // 0 idle, 1 load in flight, 2 store in flight
  int m_cnt = 0;
  logic e_cv = 0, e_cw = 0, e_err = 0;
  logic [LW-1:0] e_cl = '0;
  logic [DW-1:0] e_cd = '0;
  string tag_ovr = "";

  function automatic bit b_fits(input logic [1:0] k, input int st);
    return (k == 2'b01 && st == 1) || (k == 2'b10 && st == 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rv, input bit rw, input int rl, input logic [DW-1:0] wd,
                      input bit dr, input bit sv, input logic [1:0] sk, input int sl,
                      input logic [DW-1:0] sd);
    bit e_dnv, ok, busy;
    string ct;
    @(negedge clk);
    ct = (tag_ovr != "") ? tag_ovr : (e_cw ? "R7" : "R6");
    chk(cmp_valid == e_cv, ct, 32'(cmp_valid), 32'(e_cv));
    chk(rsp_err == e_err, "R8", 32'(rsp_err), 32'(e_err));
    if (e_cv) begin
      chk(cmp_line == e_cl, ct, 32'(cmp_line), 32'(e_cl));
      chk(cmp_write == e_cw, ct, 32'(cmp_write), 32'(e_cw));
      chk(cmp_data == e_cd, ct, cmp_data, e_cd);
    end
    req_valid = rv; req_write = rw; req_line = LW'(rl); req_wdata = wd; dn_ready = dr;
    rsp_valid = sv; rsp_kind = sk; rsp_line = LW'(sl); rsp_data = sd;
    #1;
    busy = (m_st[rl & 15] != 0);
    e_dnv = rv && !busy && (m_cnt < DEPTH);
    chk(dn_valid == e_dnv, (rv && busy) ? "R4" : ((m_cnt >= DEPTH) ? "R5" : "R2"),
        32'(dn_valid), 32'(e_dnv));
    chk(req_ready == (e_dnv && dr), "R2", 32'(req_ready), 32'(e_dnv && dr));
    chk(rsp_ready == 1'b1, "R9", 32'(rsp_ready), 32'd1);
    if (e_dnv) begin
      chk(dn_line == LW'(rl), "R2", 32'(dn_line), 32'(rl));
      chk(dn_write == rw, "R3", 32'(dn_write), 32'(rw));
      chk(dn_wdata == wd, "R3", dn_wdata, wd);
    end
    ok = sv && b_fits(sk, m_st[sl & 15]);
    e_cv = ok; e_err = sv && !ok;
    e_cl = LW'(sl); e_cw = (sk == 2'b10);
    e_cd = (sk == 2'b01) ? sd : '0;
    if (ok) begin m_st[sl & 15] = 0; m_cnt--; end
    if (e_dnv && dr) begin m_st[rl & 15] = rw ? 2 : 1; m_cnt++; end
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 1, 0, 2'b00, 0, '0);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pick, st0;
    logic [1:0] k;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m_st[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmp_valid == 0, "R1", 32'(cmp_valid), 0);
    chk(rsp_err == 0, "R1", 32'(rsp_err), 0);
    rst_n = 1'b1;
    // R1: first request after reset is offered.
    step(1, 0, 2, 32'h11, 0, 0, 2'b00, 0, '0);
    chk(dn_valid == 1, "R1", 32'(dn_valid), 1);
    // R10: fill the table with four distinct lines.
    step(1, 0, 1, 32'h0, 1, 0, 2'b00, 0, '0);
    step(1, 1, 3, 32'hA5A5, 1, 0, 2'b00, 0, '0);
    step(1, 0, 5, 32'h0, 1, 0, 2'b00, 0, '0);
    step(1, 1, 7, 32'h77, 1, 0, 2'b00, 0, '0);
    chk(m_cnt == DEPTH, "R10", 32'(m_cnt), 32'(DEPTH));
    // R5: a fifth line is held back.
    step(1, 0, 9, 32'h0, 1, 0, 2'b00, 0, '0);
    chk(req_ready == 0, "R5", 32'(req_ready), 0);
    // R9: complete line 7 then line 1, out of issue order.
    tag_ovr = "R9";
    step(0, 0, 0, '0, 1, 1, 2'b10, 7, '0);
    step(0, 0, 0, '0, 1, 1, 2'b01, 1, 32'hDEADBEEF);
    idle();
    tag_ovr = "";
    // R8: bad kind, unknown line, wrong kind for the slot.
    step(0, 0, 0, '0, 1, 1, 2'b11, 3, '0);
    step(0, 0, 0, '0, 1, 1, 2'b01, 12, 32'h5);
    step(0, 0, 0, '0, 1, 1, 2'b01, 3, 32'h6);
    idle();
    // R4: request to busy line 5 while it completes, then accepted next cycle.
    step(1, 1, 5, 32'hBB, 1, 1, 2'b01, 5, 32'hC0FFEE);
    chk(req_ready == 0, "R4", 32'(req_ready), 0);
    step(1, 1, 5, 32'hBB, 1, 0, 2'b00, 0, '0);
    chk(req_ready == 1, "R4", 32'(req_ready), 1);
    idle();
    // Random phase over a small line pool.
    for (int c = 0; c < 4000; c++) begin
      int sl;
      bit sv;
      sv = ($urandom % 2) == 0;
      pick = $urandom % 10;
      sl = $urandom % 6;
      k = 2'($urandom % 4);
      if (pick < 7) begin
        st0 = $urandom % 16;
        for (int j = 0; j < 16; j++) begin
          if (m_st[(st0 + j) % 16] != 0) begin
            sl = (st0 + j) % 16;
            k = (m_st[sl] == 1) ? 2'b01 : 2'b10;
            break;
          end
        end
      end
      step(($urandom % 3) != 0, $urandom % 2, $urandom % 6, $urandom,
           ($urandom % 4) != 0, sv, k, sl, $urandom);
    end
    idle();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule